// File: doc/BRIEF.md
# Recursive moving average filter

This block smooths a stream of fixed-point samples by producing, for every accepted input, the mean of that input and the samples that came just before it, over a window whose length is a power of two. It does not store raw samples. A running integrator adds each new sample. A chain of registers holds earlier integrator values, and the window sum is the new integrator value minus the value from one full window back. Each output therefore costs one addition and one subtraction, whatever the window length.

A sample enters when its strobe is high. The average appears on the output register one clock later, with its own strobe, and the register holds that value until the next accepted sample. The window length, the sample width and the signedness of the samples are parameters. After a reset, all history is zero. Until the window has filled, the missing samples count as zeros.

Top module: `recursive_mavg`

## Requirements
- R1: For each accepted sample, `out_avg` equals the sum of that sample and the previous 2^WIN_LOG2-1 accepted samples, divided by the window length 2^WIN_LOG2.
- R2: The division rounds toward negative infinity. For example, a window sum of -9 over a window of 4 gives -3.
- R3: With SIGNED_IN=1, `in_sample` and `out_avg` are two's-complement values. A sample of all ones counts as -1.
- R4: With SIGNED_IN=0, `in_sample` is zero-extended and `out_avg` is unsigned. A sample of all ones counts as 2^DATA_W-1.
- R5: While `rst` is high at a rising edge, `out_valid` and `out_avg` are cleared to 0, along with the integrator and every delay stage.
- R6: For the first samples after reset, before the window has filled, the average treats the missing older samples as zero.
- R7: `out_valid` is high in the cycle after an edge where `in_valid` was high, and low in the cycle after an edge where it was low.
- R8: When `in_valid` is low, `out_avg` keeps its value, and `in_sample` does not enter the window.
- R9: Full-scale inputs held over a window give the full-scale value at the output. Integrator wraparound does not corrupt the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Input sample |
| out_valid | output | 1 | Average strobe, one clock after `in_valid` |
| out_avg | output | DATA_W | Windowed average, held between strobes |

## Verification
The assertions assume that `rst` is high at the first clock edge, so that the history the checker tracks starts from a known all-zero state. They also assume that `in_valid` and `in_sample` are settled at every rising edge. The bench meets both conditions: it holds reset over the opening edges and changes inputs only on falling edges. The flat-window property only fires after a full window of equal samples. For that reason the stimulus includes runs of repeated values, at full scale and at zero, as well as varying patterns.

// File: rtl/recursive_mavg.sv
module recursive_mavg #(
  parameter int DATA_W    = 12,
  parameter int WIN_LOG2  = 3,
  parameter bit SIGNED_IN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_avg
);
  localparam int WIN   = 1 << WIN_LOG2;
  localparam int ACC_W = DATA_W + WIN_LOG2 + 1;
  localparam int EXT_W = ACC_W - DATA_W;

  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] acc_next;
  logic signed [ACC_W-1:0] win_sum;
  // hist[0] is the integrator h[n-1]; hist[k] holds h[n-1-k]
  logic signed [ACC_W-1:0] hist [WIN];

  generate
    if (SIGNED_IN) begin : g_sext
      assign x_ext = {{EXT_W{in_sample[DATA_W-1]}}, in_sample};
    end else begin : g_zext
      assign x_ext = {{EXT_W{1'b0}}, in_sample};
    end
  endgenerate

  assign acc_next = hist[0] + x_ext;
  assign win_sum  = acc_next - hist[WIN-1];

  always_ff @(posedge clk) begin
    if (rst)           hist[0] <= '0;
    else if (in_valid) hist[0] <= acc_next;
  end

  generate
    for (genvar k = 1; k < WIN; k++) begin : g_dly
      always_ff @(posedge clk) begin
        if (rst)           hist[k] <= '0;
        else if (in_valid) hist[k] <= hist[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_avg   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_avg <= DATA_W'(win_sum >>> WIN_LOG2);
    end
  end
endmodule

// File: rtl/recursive_mavg_chk.sv
module recursive_mavg_chk #(
  parameter int DATA_W   = 12,
  parameter int WIN_LOG2 = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_sample,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_avg
);
  localparam int WIN = 1 << WIN_LOG2;

  logic [DATA_W-1:0] last;
  int                run;

  always_ff @(posedge clk) begin
    if (rst) begin
      last <= '0;
      run  <= WIN;
    end else if (in_valid) begin
      last <= in_sample;
      if (in_sample != last) run <= 1;
      else if (run < WIN)    run <= run + 1;
    end
  end

  assert_reset_clear_R5: assert property (@(posedge clk)
    rst |=> (!out_valid && out_avg == '0));

  assert_strobe_follows_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_no_spurious_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_avg));

  assert_flat_window_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && run >= WIN - 1 && in_sample == last) |=> (out_avg == $past(in_sample)));
endmodule

bind recursive_mavg recursive_mavg_chk #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .out_valid(out_valid), .out_avg(out_avg)
);

// File: tb/recursive_mavg_test.sv
module recursive_mavg_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int WL  = 2;
  localparam int WIN = 1 << WL;

  // {valid, sample, expected signed average}
  localparam logic [16:0] VEC [9] = '{
    {1'b1, 8'd8,   8'd2},
    {1'b1, 8'd4,   8'd3},
    {1'b0, 8'd100, 8'd3},
    {1'b1, 8'hFC,  8'd2},
    {1'b1, 8'd12,  8'd5},
    {1'b1, 8'd0,   8'd3},
    {1'b1, 8'hEC,  8'hFD},
    {1'b1, 8'hFF,  8'hFD},
    {1'b1, 8'd3,   8'hFB}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_sample = '0;
  logic out_valid, out_valid_u;
  logic [DW-1:0] out_avg, out_avg_u;

  int checks = 0;
  int errors = 0;
  int hs [WIN];
  int hu [WIN];
  int es = 0;
  int eu = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  recursive_mavg #(.DATA_W(DW), .WIN_LOG2(WL), .SIGNED_IN(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_avg(out_avg));

  recursive_mavg #(.DATA_W(DW), .WIN_LOG2(WL), .SIGNED_IN(1'b0)) uut_u (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid_u), .out_avg(out_avg_u));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < WIN; k++) begin hs[k] = 0; hu[k] = 0; end
    es = 0;
    eu = 0;
  endtask

  task automatic apply(input bit v, input logic [DW-1:0] s, input string tag);
    int ss, su;
    in_valid  = v;
    in_sample = s;
    if (v) begin
      for (int k = WIN - 1; k > 0; k--) begin hs[k] = hs[k-1]; hu[k] = hu[k-1]; end
      hs[0] = int'($signed(s));
      hu[0] = int'(s);
      ss = 0;
      su = 0;
      for (int k = 0; k < WIN; k++) begin ss += hs[k]; su += hu[k]; end
      es = (ss >>> WL) & 255;
      eu = (su >>> WL) & 255;
    end
    @(negedge clk);
    check({tag, " R7 strobe"}, int'(out_valid), int'(v));
    check({tag, " R7 strobe u"}, int'(out_valid_u), int'(v));
    check({tag, " signed R3"}, int'(out_avg), es);
    check({tag, " unsigned R4"}, int'(out_avg_u), eu);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset();
    check("R5 reset valid", int'(out_valid), 0);
    check("R5 reset avg", int'(out_avg), 0);

    foreach (VEC[i]) begin
      apply(VEC[i][16], VEC[i][15:8], "R1/R2/R8 table");
      check("R1/R2/R8 table expected", int'(out_avg), int'(VEC[i][7:0]));
    end

    for (int i = 0; i < 6; i++) apply(1'b1, 8'd127, "R9 max");
    check("R9 full-scale positive", int'(out_avg), 127);
    for (int i = 0; i < 6; i++) apply(1'b1, 8'h80, "R9 min");
    check("R9 full-scale negative", int'(out_avg), 128);
    for (int i = 0; i < 6; i++) apply(1'b1, 8'hFF, "R9 umax");
    check("R9 unsigned full scale", int'(out_avg_u), 255);

    apply(1'b0, 8'd55, "R8 ignored");
    apply(1'b1, 8'hFF, "R8 after idle");
    check("R8 ignored sample left window intact", int'(out_avg_u), 255);

    in_valid = 1'b1;
    in_sample = 8'd99;
    do_reset();
    check("R5 mid-stream valid", int'(out_valid), 0);
    check("R5 mid-stream avg", int'(out_avg), 0);
    check("R5 mid-stream avg u", int'(out_avg_u), 0);
    apply(1'b1, 8'd40, "R6 partial");
    check("R6 first partial", int'(out_avg), 10);
    apply(1'b1, 8'd40, "R6 partial");
    check("R6 second partial", int'(out_avg), 20);

    do_reset();
    apply(1'b1, 8'hFF, "R3/R4 all ones");
    check("R3 all ones is -1, floor to -1", int'(out_avg), 255);
    check("R4 all ones is 255, floor to 63", int'(out_avg_u), 63);

    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[9:8] != 2'b00, lfsr[7:0], "R1 mixed");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule